// File: doc/BRIEF.md
# Speculative Access Tracking Table

This block records which of four ordered speculative threads, one per processor, have read or written each word of the memory lines they touch. Each tracked line occupies one entry of a set-associative table. An entry keeps, for every word and every processor, a read mark and a write mark. The ordering of the threads is given by a rotating head pointer. The head is the least speculative thread. Every other thread is ranked by its distance after the head, counted modulo 4.

A processor reports each access with its id, the line address and the word offset. For a load, the block names the thread whose write is the nearest visible version at or before the requester in thread order. If no such thread exists, it flags that the safe memory copy must be used. For a store, it returns one bit per processor marking the later threads that already consumed a stale value and must be squashed. An intervening writer shields readers behind it. Answers appear a fixed number of cycles after the request.

A commit retires the head thread's marks and advances the head. A squash request discards the marks of a thread and of every thread after it. Entries left with no marks are released. When a new line maps to a full set, the requester is told to stall and no entry is evicted.

Top module: `smdt_table`

## Requirements
- R1: A line address is split into a set index (low log2(ENTRIES/WAYS) bits) and a tag (the remaining bits). Repeated accesses to a tracked line reuse its entry and do not consume another way.
- R2: A load answers with rsp_safe=0 and rsp_owner equal to the nearest processor whose write mark is set for that word. The search starts at the requester's own rank and moves toward the head.
- R3: A load for which no processor at or before the requester's rank has written the word answers rsp_safe=1.
- R4: A store sets the storer's write mark. rsp_squash bit p (bit index = processor id) is set for each later-ranked processor p whose read mark is set for that word.
- R5: A later reader is not flagged when a processor ranked strictly between the storer and that reader holds a write mark for the same word.
- R6: Loads never flag a squash. A store never flags a reader ranked at or before the storer (WAR, WAW). A store never flags a reader that only marked a different word of the line.
- R7: A load by a processor that already holds its own write mark for the word does not set its read mark. A later store by an earlier thread therefore does not flag it.
- R8: The response to an accepted access has rsp_valid high for exactly one cycle. That cycle is the fourth cycle after the cycle in which the request was presented (LAT=4).
- R9: An access to an untracked line whose set has no free way answers rsp_stall=1, rsp_safe=0 and rsp_squash=0. It changes no table state.
- R10: A commit clears every mark of the head processor in all entries, releases entries left empty, and advances head_proc by one modulo 4.
- R11: A squash request for processor q clears the marks of every processor whose rank is at least q's rank. It releases empty entries and leaves head_proc unchanged.
- R12: Requests in the same cycle are prioritised squash, then commit, then access. A lower-priority request presented together with a higher one is dropped and gives no response.
- R13: After reset, head_proc=0, the table holds no lines, and rsp_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access request present |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_proc | input | 2 | Requesting processor id |
| acc_line | input | ADDR_W | Line address |
| acc_word | input | log2(WORDS) | Word offset within the line |
| commit_req | input | 1 | Retire the head thread |
| squash_req | input | 1 | Discard a thread and all later threads |
| squash_proc | input | 2 | First processor to discard |
| rsp_valid | output | 1 | Response present |
| rsp_stall | output | 1 | Set full, access not recorded |
| rsp_safe | output | 1 | Load must use the non-speculative copy |
| rsp_owner | output | 2 | Processor holding the version to read |
| rsp_squash | output | 4 | Processors to squash, one bit each |
| head_proc | output | 2 | Current least speculative processor |

## Verification
Version lookup is swept over every combination of writer set and requesting processor, under all four head positions. This separates rank-relative searching from plain processor-id order. It also separates "nearest earlier writer" from "any writer". Squash detection is swept over every storer, every prior writer set and every reader set on one word. This tells true violations apart from shielded readers, own-write reads, WAR and WAW cases. Directed sequences fill a set to its limit to observe stalling and release after commit. They also cover partial squash, the response latency, and requests that collide in one cycle.

// File: rtl/smdt_pkg.sv
package smdt_pkg;

    localparam int PROCS = 4;
    localparam int PID_W = $clog2(PROCS);

    typedef logic [PID_W-1:0] pid_t;
    typedef logic [PROCS-1:0] pvec_t;

    typedef struct packed {
        logic  stall;
        logic  safe;
        pid_t  owner;
        pvec_t squash;
    } rsp_t;

    // Distance of a processor after the head; PROCS is a power of two.
    function automatic pid_t rank_of(pid_t p, pid_t head);
        return p - head;
    endfunction

endpackage

// File: rtl/smdt_decide.sv
module smdt_decide
    import smdt_pkg::*;
(
    input  pid_t  head,
    input  pid_t  proc,
    input  logic  is_store,
    input  pvec_t ld_bits,
    input  pvec_t st_bits,
    output pid_t  owner,
    output logic  safe,
    output pvec_t squash
);

    pid_t  rq;
    pid_t  scan;
    logic  found;
    logic  shield;

    always_comb begin
        rq     = rank_of(proc, head);
        found  = 1'b0;
        owner  = '0;
        shield = 1'b0;
        squash = '0;
        scan   = '0;
        // nearest writer at or before the requester
        for (int d = 0; d < PROCS; d++) begin
            scan = proc - pid_t'(d);
            if (!found && (d <= int'(rq)) && st_bits[scan]) begin
                found = 1'b1;
                owner = scan;
            end
        end
        // later readers, stopping at the first intervening writer
        for (int d = 1; d < PROCS; d++) begin
            scan = proc + pid_t'(d);
            if (int'(rq) + d < PROCS) begin
                if (!shield && ld_bits[scan]) squash[scan] = 1'b1;
                if (st_bits[scan]) shield = 1'b1;
            end
        end
        if (is_store) begin
            owner = '0;
            safe  = 1'b0;
        end else begin
            squash = '0;
            safe   = !found;
        end
    end

endmodule

// File: rtl/smdt_pipe.sv
module smdt_pipe #(
    parameter int W   = 8,
    parameter int LAT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);

    typedef struct packed {
        logic [LAT-1:0]        v;
        logic [LAT-1:0][W-1:0] d;
    } pipe_t;

    pipe_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        p_d.v[0] = in_valid;
        p_d.d[0] = in_data;
        for (int i = 1; i < LAT; i++) begin
            p_d.v[i] = p_q.v[i-1];
            p_d.d[i] = p_q.d[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign out_valid = p_q.v[LAT-1];
    assign out_data  = p_q.d[LAT-1];

endmodule

// File: rtl/smdt_table.sv
module smdt_table
    import smdt_pkg::*;
#(
    parameter int ENTRIES = 512,
    parameter int WAYS    = 8,
    parameter int WORDS   = 4,
    parameter int ADDR_W  = 16,
    parameter int LAT     = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc_valid,
    input  logic                     acc_store,
    input  logic [1:0]               acc_proc,
    input  logic [ADDR_W-1:0]        acc_line,
    input  logic [$clog2(WORDS)-1:0] acc_word,
    input  logic                     commit_req,
    input  logic                     squash_req,
    input  logic [1:0]               squash_proc,
    output logic                     rsp_valid,
    output logic                     rsp_stall,
    output logic                     rsp_safe,
    output logic [1:0]               rsp_owner,
    output logic [3:0]               rsp_squash,
    output logic [1:0]               head_proc
);

    localparam int SETS  = ENTRIES / WAYS;
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - SET_W;
    localparam int WAY_W = $clog2(WAYS);

    typedef logic [WORDS-1:0][PROCS-1:0] wbits_t;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        wbits_t           ld;
        wbits_t           st;
    } entry_t;

    typedef struct packed {
        pid_t                              head;
        entry_t [SETS-1:0][WAYS-1:0]       tbl;
    } state_t;

    state_t s_d, s_q;

    logic [SET_W-1:0] set_idx;
    logic [TAG_W-1:0] tag_in;
    logic [WAYS-1:0]  hit_vec, free_vec;
    logic [WAY_W-1:0] hit_w, free_w;
    logic             any_hit, any_free;
    entry_t           cur, upd;
    pvec_t            ld_word, st_word, keep;
    logic             do_sq, do_cm, do_acc, stall;
    pid_t             dec_owner;
    logic             dec_safe;
    pvec_t            dec_squash;
    rsp_t             rsp_in, rsp_out;
    logic             rsp_v;

    assign set_idx = acc_line[SET_W-1:0];
    assign tag_in  = acc_line[ADDR_W-1:SET_W];
    assign do_sq   = squash_req;
    assign do_cm   = commit_req && !squash_req;
    assign do_acc  = acc_valid && !squash_req && !commit_req;

    // way lookup in the indexed set
    always_comb begin
        hit_w  = '0;
        free_w = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w]  = s_q.tbl[set_idx][w].valid && (s_q.tbl[set_idx][w].tag == tag_in);
            free_vec[w] = !s_q.tbl[set_idx][w].valid;
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w])  hit_w  = WAY_W'(w);
            if (free_vec[w]) free_w = WAY_W'(w);
        end
        any_hit  = |hit_vec;
        any_free = |free_vec;
        cur      = any_hit ? s_q.tbl[set_idx][hit_w] : '0;
        ld_word  = cur.ld[acc_word];
        st_word  = cur.st[acc_word];
        stall    = do_acc && !any_hit && !any_free;
    end

    smdt_decide u_decide (
        .head     (s_q.head),
        .proc     (acc_proc),
        .is_store (acc_store),
        .ld_bits  (ld_word),
        .st_bits  (st_word),
        .owner    (dec_owner),
        .safe     (dec_safe),
        .squash   (dec_squash)
    );

    // next state
    always_comb begin
        s_d  = s_q;
        keep = '1;
        upd  = cur;
        if (do_sq) begin
            for (int p = 0; p < PROCS; p++)
                if (rank_of(pid_t'(p), s_q.head) >= rank_of(squash_proc, s_q.head))
                    keep[p] = 1'b0;
        end else if (do_cm) begin
            keep[s_q.head] = 1'b0;
        end
        if (do_sq || do_cm) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    for (int k = 0; k < WORDS; k++) begin
                        s_d.tbl[s][w].ld[k] = s_q.tbl[s][w].ld[k] & keep;
                        s_d.tbl[s][w].st[k] = s_q.tbl[s][w].st[k] & keep;
                    end
                    if ((s_d.tbl[s][w].ld == '0) && (s_d.tbl[s][w].st == '0))
                        s_d.tbl[s][w].valid = 1'b0;
                end
            end
            if (do_cm) s_d.head = s_q.head + 1'b1;
        end else if (do_acc && !stall) begin
            upd.valid = 1'b1;
            upd.tag   = tag_in;
            if (acc_store)              upd.st[acc_word][acc_proc] = 1'b1;
            else if (!st_word[acc_proc]) upd.ld[acc_word][acc_proc] = 1'b1;
            s_d.tbl[set_idx][any_hit ? hit_w : free_w] = upd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rsp_in.stall  = stall;
        rsp_in.safe   = stall ? 1'b0 : dec_safe;
        rsp_in.owner  = stall ? '0 : dec_owner;
        rsp_in.squash = stall ? '0 : dec_squash;
    end

    smdt_pipe #(.W($bits(rsp_t)), .LAT(LAT)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (do_acc),
        .in_data   (rsp_in),
        .out_valid (rsp_v),
        .out_data  (rsp_out)
    );

    assign rsp_valid  = rsp_v;
    assign rsp_stall  = rsp_out.stall;
    assign rsp_safe   = rsp_out.safe;
    assign rsp_owner  = rsp_out.owner;
    assign rsp_squash = rsp_out.squash;
    assign head_proc  = s_q.head;

    // later-thread mask, built from ranks independently of the decision loop
    pvec_t later_mask;
    always_comb begin
        for (int p = 0; p < PROCS; p++)
            later_mask[p] = rank_of(pid_t'(p), s_q.head) > rank_of(acc_proc, s_q.head);
    end

    p_single_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $onehot0(hit_vec));

    p_squash_later_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (do_acc && acc_store) |-> ((dec_squash & ~later_mask) == '0));

    p_load_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (do_acc && !acc_store) |-> (dec_squash == '0));

    p_stall_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_stall) |-> (!rsp_safe && (rsp_squash == '0)));

    p_head_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        do_cm |=> (s_q.head == $past(s_q.head) + 1'b1));

    p_head_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        do_sq |=> (s_q.head == $past(s_q.head)));

endmodule

// File: tb/smdt_table_bench.sv
module smdt_table_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0, acc_store = 1'b0;
    logic [1:0] acc_proc = '0;
    logic [15:0] acc_line = '0;
    logic [1:0] acc_word = '0;
    logic       commit_req = 1'b0, squash_req = 1'b0;
    logic [1:0] squash_proc = '0;
    logic       rsp_valid, rsp_stall, rsp_safe;
    logic [1:0] rsp_owner;
    logic [3:0] rsp_squash;
    logic [1:0] head_proc;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    smdt_table u_smdt_table (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_store(acc_store),
        .acc_proc(acc_proc), .acc_line(acc_line), .acc_word(acc_word),
        .commit_req(commit_req), .squash_req(squash_req), .squash_proc(squash_proc),
        .rsp_valid(rsp_valid), .rsp_stall(rsp_stall), .rsp_safe(rsp_safe),
        .rsp_owner(rsp_owner), .rsp_squash(rsp_squash), .head_proc(head_proc)
    );

    // reference model: key = line*4 + word
    bit [3:0] mld[int];
    bit [3:0] mst[int];
    bit       live[int];
    int       head_m = 0;

    function automatic bit [3:0] gl(int k); return mld.exists(k) ? mld[k] : 4'b0; endfunction
    function automatic bit [3:0] gs(int k); return mst.exists(k) ? mst[k] : 4'b0; endfunction
    function automatic int rk(int p); return (p - head_m + 4) % 4; endfunction

    function automatic int set_count(int line);
        int n = 0;
        foreach (live[l]) if ((l % 64) == (line % 64)) n++;
        return n;
    endfunction

    function automatic void clear_model(bit [3:0] keep);
        foreach (mld[k]) mld[k] &= keep;
        foreach (mst[k]) mst[k] &= keep;
        live.delete();
        foreach (mld[k]) if (mld[k] != 0) live[k / 4] = 1'b1;
        foreach (mst[k]) if (mst[k] != 0) live[k / 4] = 1'b1;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one access, checked against the model; called and returns at a negedge
    task automatic access(bit st, int p, int line, int w, string req);
        int  k = line * 4 + w;
        bit  exp_stall = !live.exists(line) && (set_count(line) >= 8);
        bit  exp_safe = 1'b1;
        int  exp_own = 0;
        bit [3:0] exp_sq = 4'b0;
        bit  shield = 1'b0;
        if (!st) begin
            for (int d = 0; d <= rk(p); d++) begin
                int q = (p - d + 4) % 4;
                if (exp_safe && gs(k)[q]) begin exp_safe = 1'b0; exp_own = q; end
            end
        end else begin
            exp_safe = 1'b0;
            for (int d = 1; d < 4; d++) begin
                if (rk(p) + d < 4) begin
                    int q = (p + d) % 4;
                    if (!shield && gl(k)[q]) exp_sq[q] = 1'b1;
                    if (gs(k)[q]) shield = 1'b1;
                end
            end
        end
        if (exp_stall) begin exp_safe = 1'b0; exp_own = 0; exp_sq = 4'b0; end
        else begin
            live[line] = 1'b1;
            if (st) mst[k] = gs(k) | (4'b1 << p);
            else if (!gs(k)[p]) mld[k] = gl(k) | (4'b1 << p);
        end
        acc_valid = 1'b1; acc_store = st; acc_proc = 2'(p);
        acc_line = 16'(line); acc_word = 2'(w);
        @(negedge clk);
        acc_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b1, "R8", "rsp_valid", rsp_valid, 1);
        chk(rsp_stall == exp_stall, exp_stall ? "R9" : "R1", "rsp_stall", rsp_stall, exp_stall);
        if (st) chk(rsp_squash == exp_sq, req, "rsp_squash", rsp_squash, exp_sq);
        else begin
            chk(rsp_safe == exp_safe, req, "rsp_safe", rsp_safe, exp_safe);
            if (!exp_safe && !exp_stall) chk(rsp_owner == 2'(exp_own), req, "rsp_owner", rsp_owner, exp_own);
        end
    endtask

    task automatic commit();
        commit_req = 1'b1;
        @(negedge clk);
        commit_req = 1'b0;
        clear_model(~(4'b1 << head_m));
        head_m = (head_m + 1) % 4;
        chk(head_proc == 2'(head_m), "R10", "head_proc", head_proc, head_m);
    endtask

    task automatic squash(int q);
        bit [3:0] keep = 4'hF;
        for (int p = 0; p < 4; p++) if (rk(p) >= rk(q)) keep[p] = 1'b0;
        squash_req = 1'b1; squash_proc = 2'(q);
        @(negedge clk);
        squash_req = 1'b0;
        clear_model(keep);
        chk(head_proc == 2'(head_m), "R11", "head_proc", head_proc, head_m);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0, "R13", "rsp_valid in reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(head_proc == 2'd0, "R13", "head_proc", head_proc, 0);
        chk(rsp_valid == 1'b0, "R13", "rsp_valid idle", rsp_valid, 0);

        // R8: latency, response only in the fourth cycle
        acc_valid = 1'b1; acc_store = 1'b0; acc_proc = 2'd1; acc_line = 16'd900; acc_word = 2'd0;
        live[900] = 1'b1; mld[900 * 4] = 4'b0010;
        @(negedge clk);
        acc_valid = 1'b0;
        for (int c = 1; c < 4; c++) begin
            chk(rsp_valid == 1'b0, "R8", "early rsp_valid", rsp_valid, 0);
            @(negedge clk);
        end
        chk(rsp_valid == 1'b1 && rsp_safe == 1'b1, "R8", "rsp_valid on time", rsp_valid, 1);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8", "single-cycle rsp_valid", rsp_valid, 0);
        squash(head_m);

        // R2/R3: writer-set sweep under all four head positions
        for (int h = 0; h < 4; h++) begin
            for (int m = 0; m < 16; m++) begin
                int line = m + 16 * h;
                for (int p = 0; p < 4; p++) if (m[p]) access(1'b1, p, line, m % 4, "R4");
                for (int p = 0; p < 4; p++) access(1'b0, p, line, m % 4, "R2");
            end
            commit();
        end
        squash(head_m);

        // R4/R5/R6/R7: storer x prior writers x readers on one word
        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 16; m++) begin
                for (int l = 0; l < 16; l++) begin
                    for (int p = 0; p < 4; p++) if (m[p]) access(1'b1, p, 300, 1, "R6");
                    for (int p = 0; p < 4; p++) if (l[p]) access(1'b0, p, 300, 1, "R7");
                    access(1'b1, s, 300, 1, "R5");
                    squash(head_m);
                end
            end
        end

        // R6: different word of the same line
        access(1'b0, 3, 400, 0, "R6");
        access(1'b1, 0, 400, 1, "R6");
        access(1'b1, 3, 400, 2, "R6");
        access(1'b1, 0, 400, 2, "R6");
        squash(head_m);

        // R10: commit retires the head's write
        access(1'b1, head_m, 410, 0, "R4");
        access(1'b0, (head_m + 2) % 4, 410, 0, "R2");
        commit();
        access(1'b0, (head_m + 1) % 4, 410, 0, "R10");
        squash(head_m);

        // R11: partial squash keeps earlier threads
        for (int d = 0; d < 4; d++) access(1'b1, (head_m + d) % 4, 420, 0, "R4");
        squash((head_m + 2) % 4);
        access(1'b0, (head_m + 3) % 4, 420, 0, "R11");
        squash(head_m);

        // R1/R9: fill one set, reuse, stall, release after commit
        for (int k = 0; k < 8; k++) access(1'b1, head_m, 5 + 64 * k, 0, "R1");
        access(1'b1, head_m, 5, 1, "R1");
        access(1'b0, head_m, 5 + 64 * 8, 0, "R9");
        access(1'b0, (head_m + 1) % 4, 5 + 64 * 8, 0, "R9");
        commit();
        access(1'b0, head_m, 5 + 64 * 8, 0, "R10");
        squash(head_m);

        // R12: commit wins over a simultaneous access
        commit_req = 1'b1; acc_valid = 1'b1; acc_store = 1'b1;
        acc_proc = 2'((head_m + 1) % 4); acc_line = 16'd430; acc_word = 2'd0;
        @(negedge clk);
        commit_req = 1'b0; acc_valid = 1'b0;
        clear_model(~(4'b1 << head_m));
        head_m = (head_m + 1) % 4;
        chk(head_proc == 2'(head_m), "R12", "head after collision", head_proc, head_m);
        for (int c = 0; c < 4; c++) begin
            chk(rsp_valid == 1'b0, "R12", "dropped access rsp", rsp_valid, 0);
            @(negedge clk);
        end
        access(1'b0, (head_m + 2) % 4, 430, 0, "R12");
        // R12: squash wins over a simultaneous commit
        squash_req = 1'b1; commit_req = 1'b1; squash_proc = 2'(head_m);
        @(negedge clk);
        squash_req = 1'b0; commit_req = 1'b0;
        clear_model(4'b0);
        chk(head_proc == 2'(head_m), "R12", "head after squash+commit", head_proc, head_m);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule